// File: doc/BRIEF.md
# Status Byte Service Request Generator

This block forms the top-level status byte of an instrument's status reporting tree and decides when the instrument asks its controller for attention. The byte is not latched. It is assembled every cycle from live condition inputs: error queue not empty, output message available, the questionable summary, the operation summary and three spare conditions. The questionable summary is itself computed here from the questionable event and enable vectors.

A host writes and reads back an 8-bit service request enable mask through a small register port. The same port also reads the live status byte. Bit 6 of the byte is the master summary: it reads 1 when any other status bit is set together with its mask bit. The block issues a one-cycle request pulse when an enabled bit goes from 0 to 1, or when a new error is added while error reporting is enabled. A request level stays high until the host reads the status byte.

Top module: `stb_srq_gen`

## Requirements
- R1: Status bit positions: bit 2 = error queue not empty, bit 4 = message available, bit 7 = operation summary, bits 0, 1 and 5 = spare inputs 0, 1 and 2. Each bit follows its input in the same cycle, with no latching.
- R2: Status bit 3 is 1 exactly when some questionable event bit and its matching questionable enable bit are both 1.
- R3: Status bit 6 is 1 exactly when the AND of the mask and the other seven status bits is nonzero.
- R4: Mask bit 6 is not stored. It reads back as 0 and never causes a request or a summary.
- R5: When an enabled status bit (other than bit 6) is 1 in a cycle and was 0 in the previous cycle, srq_pulse is 1 in the following cycle.
- R6: A bit that stays 1, falls, or rises while its mask bit is 0 produces no request.
- R7: An error_added pulse while mask bit 2 is 1 gives a request in the following cycle, even when status bit 2 is already 1.
- R8: srq_level goes to 1 with every request and stays 1 until a host read of address 1. A request in the same cycle as that read wins.
- R9: After reset the mask is 0 and srq_pulse and srq_level are 0.
- R10: Host port: a write with host_addr=0 loads the mask. host_rdata shows the mask for host_addr=0 and the live status byte for host_addr=1, in the same cycle.
- R11: Writing a mask bit for a status bit that is already 1 raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| err_nonempty | input | 1 | Error queue holds an entry |
| err_added | input | 1 | One-cycle pulse: an entry was added to the error queue |
| msg_avail | input | 1 | A readable message is in the output buffer |
| ques_event | input | QUES_W | Questionable event register contents |
| ques_enable | input | QUES_W | Questionable enable register contents |
| oper_summary | input | 1 | Operation status summary |
| spare_cond | input | 3 | Spare conditions for status bits 0, 1, 5 |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 1 | 0 = enable mask, 1 = status byte |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data |
| status_byte | output | 8 | Live status byte |
| srq_pulse | output | 1 | One-cycle service request |
| srq_level | output | 1 | Request pending until the status byte is read |

## Verification
The bench drives random condition patterns that toggle slowly, so that it sees both rising edges and bits that stay high. Random mask writes and status reads are mixed in, which separates edge detection from level sensing and checks that a read clears the pending request. Directed sequences cover cases random stimulus rarely hits:
- Enabling a bit that is already high, which must stay silent.
- A repeated error entry with bit 2 already 1, which must fire again.
- A request in the same cycle as a status read, which must leave the level set.
- A write with mask bit 6 set, which must read back as 0 and have no effect.

// File: rtl/stb_srq_pkg.sv
package stb_srq_pkg;
  localparam int STB_W     = 8;
  localparam int BIT_SP0   = 0;
  localparam int BIT_SP1   = 1;
  localparam int BIT_ERR   = 2;
  localparam int BIT_QUES  = 3;
  localparam int BIT_MAV   = 4;
  localparam int BIT_SP2   = 5;
  localparam int BIT_SUM   = 6;
  localparam int BIT_OPER  = 7;
  localparam logic [STB_W-1:0] SUM_MASK = STB_W'(1) << BIT_SUM;

  // master summary: any non-summary bit set together with its enable
  function automatic logic summary_of(input logic [STB_W-1:0] core,
                                      input logic [STB_W-1:0] mask);
    return |(core & mask & ~SUM_MASK);
  endfunction

  // bits that went 0 -> 1 since the previous cycle
  function automatic logic [STB_W-1:0] rising(input logic [STB_W-1:0] now_v,
                                              input logic [STB_W-1:0] prev_v);
    return now_v & ~prev_v;
  endfunction
endpackage

// File: rtl/stb_assemble.sv
module stb_assemble
  import stb_srq_pkg::*;
#(
  parameter int QUES_W = 16
) (
  input  logic              err_nonempty,
  input  logic              msg_avail,
  input  logic [QUES_W-1:0] ques_event,
  input  logic [QUES_W-1:0] ques_enable,
  input  logic              oper_summary,
  input  logic [2:0]        spare_cond,
  input  logic [STB_W-1:0]  mask_eff,
  output logic [STB_W-1:0]  core_bits,
  output logic [STB_W-1:0]  status_byte
);
  logic ques_sum;
  assign ques_sum = |(ques_event & ques_enable);

  always_comb begin
    core_bits           = '0;
    core_bits[BIT_SP0]  = spare_cond[0];
    core_bits[BIT_SP1]  = spare_cond[1];
    core_bits[BIT_ERR]  = err_nonempty;
    core_bits[BIT_QUES] = ques_sum;
    core_bits[BIT_MAV]  = msg_avail;
    core_bits[BIT_SP2]  = spare_cond[2];
    core_bits[BIT_OPER] = oper_summary;
    status_byte          = core_bits;
    status_byte[BIT_SUM] = summary_of(core_bits, mask_eff);
  end
endmodule

// File: rtl/stb_rise_detect.sv
module stb_rise_detect
  import stb_srq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [STB_W-1:0] core_bits,
  input  logic [STB_W-1:0] mask_eff,
  input  logic             err_added,
  input  logic             srq_clear,
  output logic             rise_hit,
  output logic             err_hit,
  output logic             srq_pulse,
  output logic             srq_level
);
  logic [STB_W-1:0] prev_q;
  logic             fire;

  assign rise_hit = |(rising(core_bits, prev_q) & mask_eff);
  assign err_hit  = err_added & mask_eff[BIT_ERR];
  assign fire     = rise_hit | err_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q    <= '0;
      srq_pulse <= 1'b0;
      srq_level <= 1'b0;
    end else begin
      prev_q    <= core_bits;
      srq_pulse <= fire;
      if (fire)           srq_level <= 1'b1;
      else if (srq_clear) srq_level <= 1'b0;
    end
  end

  assert_rise_fires_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rise_hit |=> srq_pulse);
  assert_err_refire_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_hit |=> srq_pulse);
  assert_pulse_sets_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    srq_pulse |-> srq_level);
  assert_level_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (srq_level && !srq_clear) |=> srq_level);
endmodule

// File: rtl/stb_host_regs.sv
module stb_host_regs
  import stb_srq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic             host_addr,
  input  logic [STB_W-1:0] host_wdata,
  input  logic [STB_W-1:0] status_byte,
  output logic [STB_W-1:0] mask_eff,
  output logic [STB_W-1:0] host_rdata,
  output logic             status_read
);
  logic [STB_W-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       mask_q <= '0;
    else if (host_wr && !host_addr)   mask_q <= host_wdata & ~SUM_MASK;
  end

  assign mask_eff    = mask_q;
  assign host_rdata  = host_addr ? status_byte : mask_q;
  assign status_read = host_rd & host_addr;

  assert_mask_bit6_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !host_addr |-> !host_rdata[BIT_SUM]);
  assert_mask_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !host_addr) |=> (mask_eff == ($past(host_wdata) & ~SUM_MASK)));
endmodule

// File: rtl/stb_srq_gen.sv
module stb_srq_gen
  import stb_srq_pkg::*;
#(
  parameter int QUES_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err_nonempty,
  input  logic              err_added,
  input  logic              msg_avail,
  input  logic [QUES_W-1:0] ques_event,
  input  logic [QUES_W-1:0] ques_enable,
  input  logic              oper_summary,
  input  logic [2:0]        spare_cond,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic              host_addr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  output logic [7:0]        status_byte,
  output logic              srq_pulse,
  output logic              srq_level
);
  logic [STB_W-1:0] mask_eff;
  logic [STB_W-1:0] core_bits;
  logic             status_read;
  logic             rise_hit;
  logic             err_hit;

  stb_assemble #(.QUES_W(QUES_W)) u_asm (
    .err_nonempty(err_nonempty), .msg_avail(msg_avail),
    .ques_event(ques_event), .ques_enable(ques_enable),
    .oper_summary(oper_summary), .spare_cond(spare_cond),
    .mask_eff(mask_eff), .core_bits(core_bits), .status_byte(status_byte)
  );

  stb_host_regs u_regs (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .status_byte(status_byte),
    .mask_eff(mask_eff), .host_rdata(host_rdata), .status_read(status_read)
  );

  stb_rise_detect u_rise (
    .clk(clk), .rst_n(rst_n), .core_bits(core_bits), .mask_eff(mask_eff),
    .err_added(err_added), .srq_clear(status_read),
    .rise_hit(rise_hit), .err_hit(err_hit),
    .srq_pulse(srq_pulse), .srq_level(srq_level)
  );

  assert_summary_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    status_byte[BIT_SUM] |-> (mask_eff != '0));
endmodule

// File: tb/stb_srq_gen_tb.sv
module stb_srq_gen_tb;
  localparam int QW = 16;
  logic clk = 0, rst_n = 0;
  logic err_nonempty = 0, err_added = 0, msg_avail = 0, oper_summary = 0;
  logic [QW-1:0] ques_event = '0, ques_enable = '0;
  logic [2:0] spare_cond = '0;
  logic host_wr = 0, host_rd = 0, host_addr = 0;
  logic [7:0] host_wdata = '0, host_rdata, status_byte;
  logic srq_pulse, srq_level;

  int n_checks = 0, n_fail = 0;
  logic [7:0] m_mask = '0, m_prev = '0;
  logic m_pulse = 0, m_level = 0;
  string ptag = "R5";

  always #5 clk = ~clk;

  stb_srq_gen #(.QUES_W(QW)) u_dut (.*);

  function automatic logic [7:0] exp_core();
    logic [7:0] c;
    c = '0;
    c[0] = spare_cond[0]; c[1] = spare_cond[1]; c[5] = spare_cond[2];
    c[2] = err_nonempty; c[4] = msg_avail; c[7] = oper_summary;
    for (int i = 0; i < QW; i++) if (ques_event[i] && ques_enable[i]) c[3] = 1'b1;
    return c;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive is done at negedge before calling; checks comb, clocks, checks regs
  task automatic cycle();
    logic [7:0] c, sb, rd_e;
    logic fire;
    #1;
    c = exp_core();
    sb = c;
    sb[6] = ((c & m_mask) != 0);
    chk("R1", status_byte & 8'hB7, sb & 8'hB7);
    chk("R2", {7'd0, status_byte[3]}, {7'd0, sb[3]});
    chk("R3", {7'd0, status_byte[6]}, {7'd0, sb[6]});
    rd_e = host_addr ? sb : m_mask;
    chk("R10", host_rdata, rd_e);
    fire = ((c & ~m_prev & m_mask) != 0) || (err_added && m_mask[2]);
    @(posedge clk);
    m_prev = c;
    m_pulse = fire;
    if (fire) m_level = 1;
    else if (host_rd && host_addr) m_level = 0;
    if (host_wr && !host_addr) m_mask = host_wdata & 8'hBF;
    @(negedge clk);
    chk(ptag, {7'd0, srq_pulse}, {7'd0, m_pulse});
    chk("R8", {7'd0, srq_level}, {7'd0, m_level});
  endtask

  task automatic idle_host();
    host_wr = 0; host_rd = 0; err_added = 0;
  endtask

  initial begin
    #20000000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9: reset state
    chk("R9", {6'd0, srq_pulse, srq_level}, 8'd0);
    host_addr = 0; #1;
    chk("R9", host_rdata, 8'd0);
    cycle();

    // R11: bit 2 high before enabling; enabling must stay silent
    err_nonempty = 1; cycle();
    ptag = "R11"; host_wr = 1; host_addr = 0; host_wdata = 8'h04; cycle();
    idle_host(); cycle();
    // R7: new error entry with bit 2 already 1
    ptag = "R7"; err_added = 1; cycle(); idle_host(); cycle();
    // R6: falling and staying high give nothing; rise disabled gives nothing
    ptag = "R6"; err_nonempty = 0; cycle(); msg_avail = 1; cycle(); cycle();
    // R5: enabled rise
    ptag = "R5"; err_nonempty = 1; cycle();
    // R8: request in the same cycle as a status read keeps the level
    err_nonempty = 0; cycle();
    host_rd = 1; host_addr = 1; err_nonempty = 1; cycle();
    ptag = "R8"; cycle(); idle_host(); cycle();
    // R4: mask bit 6 written, reads back 0, no summary
    ptag = "R4"; host_wr = 1; host_addr = 0; host_wdata = 8'h40; cycle();
    idle_host(); host_addr = 0; cycle();
    chk("R4", host_rdata, 8'h00);
    host_addr = 1; #1; chk("R4", {7'd0, status_byte[6]}, 8'd0);
    cycle();

    // random phase
    ptag = "R5";
    for (int k = 0; k < 3000; k++) begin
      idle_host();
      if ($urandom % 6 == 0) err_nonempty = ~err_nonempty;
      if ($urandom % 6 == 0) msg_avail = ~msg_avail;
      if ($urandom % 6 == 0) oper_summary = ~oper_summary;
      if ($urandom % 5 == 0) spare_cond[$urandom % 3] ^= 1'b1;
      if ($urandom % 8 == 0) ques_event = QW'($urandom) & QW'($urandom);
      if ($urandom % 10 == 0) ques_enable = QW'($urandom);
      err_added = ($urandom % 8 == 0);
      host_addr = $urandom % 2;
      host_wr = ($urandom % 10 == 0);
      host_rd = ($urandom % 4 == 0);
      host_wdata = 8'($urandom);
      cycle();
    end
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule